// File: doc/BRIEF.md
# RTC Sub-Second Divider Counter

This block is the fractional-second stage of a real-time clock. A single-cycle enable pulse at 128 Hz arrives in the system clock domain. The block divides it through seven binary stages, which give 64, 32, 16, 8, 4, 2 and 1 Hz. Software can read the stage states as an 8-bit counter value. When the 1 Hz stage wraps, the block sends a one-cycle carry pulse to a downstream seconds counter.

The read path can race the divider. A read strobe that arrives in the same cycle as a 128 Hz tick latches a collision flag in the first control register. Software sees the flag, writes 0 to clear it, and then reads again. The divider has no connection to the system reset, so it keeps counting through system resets. It returns to zero only when software writes a 1 to one of two clear bits in the second control register. These two bits clear themselves.

Top module: `rtc_subsec_divider`

## Requirements
- R1: On each cycle with `tick_128` high and no clear, `cnt_rdata[6:0]` increases by one modulo 128. Bit 0 is the 64 Hz stage and bit 6 is the 1 Hz stage. With no tick and no clear, the value does not change.
- R2: `cnt_rdata[7]` always reads 0.
- R3: When `cnt_rd` and `tick_128` are high in the same cycle, the collision flag is set. The flag is bit 7 of `ctl1_rdata` and shows from the next cycle.
- R4: A write to control register 1 with data bit 7 at 0 clears the collision flag. A write with data bit 7 at 1 leaves it unchanged. A collision in the same cycle as a clearing write leaves the flag set.
- R5: A write to control register 2 with data bit 1 (divider clear) or data bit 2 (adjust) at 1 makes the counter read 0x00 in the next cycle. This clear takes priority over a tick in the same cycle.
- R6: Asserting the system reset `rst` does not change the counter value.
- R7: `sec_carry` is high for exactly the cycle in which a tick arrives with the counter at 0x7F and no clear. After that cycle the counter reads 0x00. `sec_carry` is low at all other times.
- R8: After `rst`, `ctl2_rdata` reads 0x09 and `ctl1_rdata` reads 0x00. Bits 1 and 2 of `ctl2_rdata` always read 0. The other bits of control register 2 hold the value last written. Bits 6:0 of `ctl1_rdata` read 0.
- R9: A read strobe without a tick in the same cycle leaves the collision flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset; does not touch the divider |
| tick_128 | input | 1 | Single-cycle 128 Hz enable pulse |
| cnt_rd | input | 1 | Read strobe for the sub-second counter |
| cnt_rdata | output | 8 | Counter value; bit 7 reads 0 |
| ctl1_wr | input | 1 | Write strobe for control register 1 |
| ctl2_wr | input | 1 | Write strobe for control register 2 |
| wdata | input | 8 | Write data shared by both control registers |
| ctl1_rdata | output | 8 | Control register 1; bit 7 is the collision flag |
| ctl2_rdata | output | 8 | Control register 2; bits 1 and 2 read 0 |
| sec_carry | output | 1 | One-cycle carry out of the 1 Hz stage |

## Verification
The bench first drives a short run of isolated ticks, which shows that the count increases by one and that the counter holds while no tick arrives. It then drives a full run of 128 ticks from zero, which shows the wrap and the single carry pulse and separates correct carry propagation into the upper stages from a chain that stops early. The collision flag gets four patterns: a read alone, a read with a tick, a write of 1, and a clearing write in the same cycle as a new collision. Together these separate set priority from clear priority. The clear bits are tried one at a time and together with a tick, and a system reset is applied in the middle of a count to show that the divider keeps its value.

// File: rtl/rtc_subsec_pkg.sv
package rtc_subsec_pkg;
    localparam int NSTAGES  = 7;
    localparam int REG_W    = 8;
    localparam int CF_BIT   = 7;
    localparam int CLR_BIT  = 1;
    localparam int ADJ_BIT  = 2;
    localparam logic [REG_W-1:0] CTL2_INIT = 8'h09;
    localparam logic [REG_W-1:0] CTL2_KEEP = ~((8'h1 << CLR_BIT) | (8'h1 << ADJ_BIT));

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic logic clear_req(input reg_wr_t w);
        return w.wr && (w.data[CLR_BIT] || w.data[ADJ_BIT]);
    endfunction
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int N = rtc_subsec_pkg::NSTAGES
) (
    input  logic         clk,
    input  logic         tick,
    input  logic         clr,
    output logic [N-1:0] q,
    output logic         carry
);
    logic [N-1:0] en;

    assign en[0] = tick;

    generate
        for (genvar i = 1; i < N; i++) begin : g_en
            assign en[i] = en[i-1] & q[i-1];
        end
        for (genvar i = 0; i < N; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (clr)
                    q[i] <= 1'b0;
                else if (en[i])
                    q[i] <= ~q[i];
            end
        end
    endgenerate

    assign carry = en[N-1] & q[N-1] & ~clr;
endmodule

// File: rtl/rtc_cf_flag.sv
module rtc_cf_flag
    import rtc_subsec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd,
    input  logic    tick,
    input  reg_wr_t w,
    output logic    cf
);
    always_ff @(posedge clk) begin
        if (rst)
            cf <= 1'b0;
        else if (rd && tick)
            cf <= 1'b1;
        else if (w.wr && !w.data[CF_BIT])
            cf <= 1'b0;
    end
endmodule

// File: rtl/rtc_ctl2_reg.sv
module rtc_ctl2_reg
    import rtc_subsec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          w,
    output logic [REG_W-1:0] value,
    output logic             clr
);
    logic [REG_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= CTL2_INIT;
        else if (w.wr)
            held <= w.data & CTL2_KEEP;
    end

    assign value = held;
    assign clr   = clear_req(w);
endmodule

// File: rtl/rtc_subsec_divider.sv
module rtc_subsec_divider
    import rtc_subsec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_128,
    input  logic             cnt_rd,
    output logic [REG_W-1:0] cnt_rdata,
    input  logic             ctl1_wr,
    input  logic             ctl2_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl1_rdata,
    output logic [REG_W-1:0] ctl2_rdata,
    output logic             sec_carry
);
    localparam int PAD_W = REG_W - NSTAGES;

    reg_wr_t            w1, w2;
    logic               div_clr;
    logic               cf;
    logic [NSTAGES-1:0] stages;

    assign w1 = '{wr: ctl1_wr, data: wdata};
    assign w2 = '{wr: ctl2_wr, data: wdata};

    rtc_ctl2_reg u_ctl2 (
        .clk   (clk),
        .rst   (rst),
        .w     (w2),
        .value (ctl2_rdata),
        .clr   (div_clr)
    );

    rtc_div_chain #(.N(NSTAGES)) u_chain (
        .clk   (clk),
        .tick  (tick_128),
        .clr   (div_clr),
        .q     (stages),
        .carry (sec_carry)
    );

    rtc_cf_flag u_cf (
        .clk  (clk),
        .rst  (rst),
        .rd   (cnt_rd),
        .tick (tick_128),
        .w    (w1),
        .cf   (cf)
    );

    assign cnt_rdata  = {{PAD_W{1'b0}}, stages};
    assign ctl1_rdata = {cf, {(REG_W-1){1'b0}}};
endmodule

// File: rtl/rtc_subsec_divider_chk.sv
module rtc_subsec_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_128,
    input logic       cnt_rd,
    input logic [7:0] cnt_rdata,
    input logic       ctl1_wr,
    input logic       ctl2_wr,
    input logic [7:0] wdata,
    input logic [7:0] ctl1_rdata,
    input logic [7:0] ctl2_rdata,
    input logic       sec_carry
);
    logic known;
    logic clr;

    assign clr = ctl2_wr && (wdata[1] || wdata[2]);

    always_ff @(posedge clk) begin
        if (rst)
            known <= 1'b0;
        else if (clr)
            known <= 1'b1;
    end

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        known && tick_128 && !clr |=> cnt_rdata[6:0] == $past(cnt_rdata[6:0]) + 7'd1);
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        known && !tick_128 && !clr |=> $stable(cnt_rdata));
    a_r2_msb_zero: assert property (@(posedge clk) disable iff (rst)
        known |-> cnt_rdata[7] == 1'b0);
    a_r3_collide: assert property (@(posedge clk) disable iff (rst)
        cnt_rd && tick_128 |=> ctl1_rdata[7]);
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        ctl1_wr && !wdata[7] && !(cnt_rd && tick_128) |=> !ctl1_rdata[7]);
    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_rdata == 8'h00);
    a_r7_carry_needs_tick: assert property (@(posedge clk) disable iff (rst)
        sec_carry |-> tick_128 && !clr);
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        sec_carry |=> cnt_rdata == 8'h00);
    a_r8_selfclr: assert property (@(posedge clk) disable iff (rst)
        ctl2_rdata[2:1] == 2'b00);
    a_r9_quiet_read: assert property (@(posedge clk) disable iff (rst)
        cnt_rd && !tick_128 && !ctl1_wr |=> $stable(ctl1_rdata[7]));
endmodule

bind rtc_subsec_divider rtc_subsec_divider_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_128   (tick_128),
    .cnt_rd     (cnt_rd),
    .cnt_rdata  (cnt_rdata),
    .ctl1_wr    (ctl1_wr),
    .ctl2_wr    (ctl2_wr),
    .wdata      (wdata),
    .ctl1_rdata (ctl1_rdata),
    .ctl2_rdata (ctl2_rdata),
    .sec_carry  (sec_carry)
);

// File: tb/test_rtc_subsec_divider.sv
module test_rtc_subsec_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_128 = 1'b0;
    logic       cnt_rd = 1'b0;
    logic       ctl1_wr = 1'b0;
    logic       ctl2_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] cnt_rdata, ctl1_rdata, ctl2_rdata;
    logic       sec_carry;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rtc_subsec_divider i_rtc_subsec_divider (
        .clk(clk), .rst(rst), .tick_128(tick_128), .cnt_rd(cnt_rd),
        .cnt_rdata(cnt_rdata), .ctl1_wr(ctl1_wr), .ctl2_wr(ctl2_wr),
        .wdata(wdata), .ctl1_rdata(ctl1_rdata), .ctl2_rdata(ctl2_rdata),
        .sec_carry(sec_carry)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        tick_128 = 0; cnt_rd = 0; ctl1_wr = 0; ctl2_wr = 0; wdata = 8'h00;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_128 = 1; cycle(); tick_128 = 0; cycle();
        end
    endtask

    task automatic clear_div(input int bitpos);
        ctl2_wr = 1; wdata = 8'h1 << bitpos; cycle(); idle();
    endtask

    task automatic t_reset_values();
        check("R8 ctl2 reset", ctl2_rdata, 8'h09);
        check("R8 ctl1 reset", ctl1_rdata, 8'h00);
    endtask

    task automatic t_count();
        clear_div(1);
        check("R5 clear bit", cnt_rdata, 8'h00);
        ticks(5);
        check("R1 five ticks", cnt_rdata, 8'h05);
        repeat (6) cycle();
        check("R1 hold without tick", cnt_rdata, 8'h05);
        ticks(58);
        check("R1 upper stages", cnt_rdata, 8'h3F);
        check("R2 msb zero", {7'h0, cnt_rdata[7]}, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] seen;
        clear_div(2);
        check("R5 adjust bit", cnt_rdata, 8'h00);
        seen = 0;
        for (int i = 0; i < 127; i++) begin
            tick_128 = 1; #1 seen = seen + {7'h0, sec_carry}; cycle(); tick_128 = 0; cycle();
        end
        check("R7 no early carry", seen, 8'h00);
        check("R7 at top", cnt_rdata, 8'h7F);
        check("R2 msb at top", {7'h0, cnt_rdata[7]}, 8'h00);
        tick_128 = 1; #1;
        check("R7 carry pulse", {7'h0, sec_carry}, 8'h01);
        cycle(); tick_128 = 0; #1;
        check("R7 carry one cycle", {7'h0, sec_carry}, 8'h00);
        check("R7 wrap to zero", cnt_rdata, 8'h00);
        cycle();
    endtask

    task automatic t_clear_priority();
        ticks(9);
        tick_128 = 1; ctl2_wr = 1; wdata = 8'h02; #1;
        check("R7 no carry on clear", {7'h0, sec_carry}, 8'h00);
        cycle(); idle();
        check("R5 clear beats tick", cnt_rdata, 8'h00);
        check("R8 self-clear readback", ctl2_rdata, 8'h00);
        ctl2_wr = 1; wdata = 8'hF0; cycle(); idle();
        check("R8 held bits", ctl2_rdata, 8'hF0);
    endtask

    task automatic t_sysreset();
        clear_div(1);
        ticks(11);
        rst = 1; repeat (3) cycle(); rst = 0; cycle();
        check("R6 survives reset", cnt_rdata, 8'h0B);
        check("R8 ctl2 after reset", ctl2_rdata, 8'h09);
    endtask

    task automatic t_collision();
        cnt_rd = 1; cycle(); idle();
        check("R9 read alone", ctl1_rdata, 8'h00);
        cnt_rd = 1; tick_128 = 1; cycle(); idle();
        check("R3 collision sets flag", ctl1_rdata, 8'h80);
        ctl1_wr = 1; wdata = 8'hFF; cycle(); idle();
        check("R4 write one no effect", ctl1_rdata, 8'h80);
        cnt_rd = 1; cycle(); idle();
        check("R9 read keeps flag", ctl1_rdata, 8'h80);
        ctl1_wr = 1; wdata = 8'h00; cycle(); idle();
        check("R4 write zero clears", ctl1_rdata, 8'h00);
        cnt_rd = 1; tick_128 = 1; ctl1_wr = 1; wdata = 8'h00; cycle(); idle();
        check("R4 set beats clear", ctl1_rdata, 8'h80);
        ctl1_wr = 1; wdata = 8'h00; cycle(); idle();
        check("R4 final clear", ctl1_rdata, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) cycle();
        rst = 0;
        cycle();
        t_reset_values();
        t_count();
        t_wrap();
        t_clear_priority();
        t_sysreset();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule